// File: doc/BRIEF.md
# Hit Capture and Serial Readout Channel

This block serves one group of pixels. It watches a single receiver pulse that has already been sampled into the clock domain. When the pulse goes high, it takes a snapshot of the fine-phase tap vector from the delay line and of the pixel-group address. When the pulse goes low, it takes a second tap snapshot and then blocks the channel. While blocked, the ready flag is up and further hits are refused.

Each 32-bit tap snapshot is reduced to a 5-bit tap index. The index marks the place where the vector changes from ones to zeros. A vector with no such change raises an error bit instead. One cycle after the trail capture, the address, the two indices and the error bit are loaded into a shift register. They leave the block on one serial line, qualified by a frame-valid strobe. When the last bit has gone out, the channel re-arms. A leading edge that arrives while the channel is blocked is discarded and counted in a saturating counter.

Top module: `hit_readout_channel`

## Requirements
- R1: After reset, `ser_out`, `frame_valid` and `ready` are 0 and `overflow_cnt` is 0.
- R2: While the channel is idle, a rising edge of `rx_pulse` (high now, low in the previous cycle) latches `fine_taps` and `grp_addr` at that clock edge. Later changes on those inputs have no effect on the frame.
- R3: After a lead capture, a falling edge of `rx_pulse` latches `fine_taps` as the trail snapshot at that clock edge. `ready` is high from the next cycle.
- R4: A tap vector is encoded to the lowest index i (0..30) for which bit i is 1 and bit i+1 is 0.
- R5: If neither snapshot nor only one snapshot lacks such a transition, the rule is this: a snapshot with no 1-to-0 transition encodes to 0. The frame's error bit is 1 if either snapshot lacks a transition.
- R6: The frame is 16 bits, sent MSB first: address[4:0], lead index[4:0], trail index[4:0], error bit. `frame_valid` rises the cycle after `ready` rises and stays high for exactly 16 cycles, one bit per cycle. `ser_out` is 0 whenever `frame_valid` is low.
- R7: `ready` and `frame_valid` fall together after the last bit. A rising edge seen at the next clock edge is accepted as a new hit.
- R8: A rising edge of `rx_pulse` while `ready` is high is dropped and does not alter the frame being sent. Each such edge increments `overflow_cnt`.
- R9: `overflow_cnt` saturates at 2^OVF_W-1 and never decreases except at reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_pulse | input | 1 | Receiver pulse, sampled on the clock |
| fine_taps | input | TAPS (32) | Delay-line tap vector |
| grp_addr | input | ADDR_W (5) | Pixel-group address |
| ser_out | output | 1 | Serial frame data, MSB first |
| frame_valid | output | 1 | High while frame bits are on `ser_out` |
| ready | output | 1 | Data held, channel blocked until readout ends |
| overflow_cnt | output | OVF_W (8) | Saturating count of dropped leading edges |

## Verification
Both snapshots are taken at the clock edge where the block first sees the new level of `rx_pulse`. The driver therefore presents the wanted taps only in the cycle of the edge and scrambles them in the next cycle. `ready` is due one cycle after the trail edge, and the driver samples it at the next falling clock edge. The first frame bit is due one cycle after that. The monitor notes the cycle in which `ready` rose, requires `frame_valid` in the following cycle, and then collects exactly 16 bits before comparing the frame with the queued expectation. The overflow count is read once the frame has ended, after the dropped pulses have been driven inside the blocked window.

// File: rtl/hit_readout_channel.sv
module hit_readout_channel #(
  parameter int TAPS   = 32,
  parameter int ADDR_W = 5,
  parameter int OVF_W  = 8,
  localparam int IDX_W   = $clog2(TAPS),
  localparam int FRAME_W = ADDR_W + 2*IDX_W + 1,
  localparam int CNT_W   = $clog2(FRAME_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_pulse,
  input  logic [TAPS-1:0]   fine_taps,
  input  logic [ADDR_W-1:0] grp_addr,
  output logic              ser_out,
  output logic              frame_valid,
  output logic              ready,
  output logic [OVF_W-1:0]  overflow_cnt
);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_HELD, S_SHIFT} st_t;

  st_t               st;
  logic              rx_q;
  logic [TAPS-1:0]   lead_hr, trail_hr;
  logic [ADDR_W-1:0] addr_hr;
  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]  bit_cnt;

  function automatic logic [IDX_W:0] tap_encode(input logic [TAPS-1:0] t);
    logic [IDX_W:0] r;
    r = {1'b1, {IDX_W{1'b0}}};
    for (int i = TAPS-2; i >= 0; i--)
      if (t[i] && !t[i+1]) r = {1'b0, IDX_W'(i)};
    return r;
  endfunction

  wire rise = rx_pulse & ~rx_q;
  wire fall = ~rx_pulse & rx_q;

  wire [IDX_W:0] lead_enc  = tap_encode(lead_hr);
  wire [IDX_W:0] trail_enc = tap_encode(trail_hr);
  wire [FRAME_W-1:0] frame = {addr_hr, lead_enc[IDX_W-1:0], trail_enc[IDX_W-1:0],
                              lead_enc[IDX_W] | trail_enc[IDX_W]};

  assign ready       = (st == S_HELD) || (st == S_SHIFT);
  assign frame_valid = (st == S_SHIFT);
  assign ser_out     = frame_valid & sh[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      rx_q         <= 1'b0;
      lead_hr      <= '0;
      trail_hr     <= '0;
      addr_hr      <= '0;
      sh           <= '0;
      bit_cnt      <= '0;
      overflow_cnt <= '0;
    end else begin
      rx_q <= rx_pulse;
      if (rise && ready && overflow_cnt != {OVF_W{1'b1}})
        overflow_cnt <= overflow_cnt + 1'b1;
      case (st)
        S_IDLE: if (rise) begin
          lead_hr <= fine_taps;
          addr_hr <= grp_addr;
          st      <= S_LEAD;
        end
        S_LEAD: if (fall) begin
          trail_hr <= fine_taps;
          st       <= S_HELD;
        end
        S_HELD: begin
          sh      <= frame;
          bit_cnt <= '0;
          st      <= S_SHIFT;
        end
        S_SHIFT: begin
          if (bit_cnt == CNT_W'(FRAME_W-1)) begin
            st <= S_IDLE;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            sh      <= {sh[FRAME_W-2:0], 1'b0};
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hit_readout_channel_chk.sv
module hit_readout_channel_chk #(
  parameter int OVF_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_pulse,
  input logic             ser_out,
  input logic             frame_valid,
  input logic             ready,
  input logic [OVF_W-1:0] overflow_cnt
);

  assert_quiet_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |-> !ser_out);

  assert_valid_inside_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> ready);

  assert_ready_after_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (!$past(rx_pulse) && $past(rx_pulse, 2)));

  assert_shift_follows_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |=> $rose(frame_valid));

  assert_rearm_together_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_valid) |-> !ready);

  assert_no_overflow_decrease_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_cnt >= $past(overflow_cnt));

  assert_overflow_only_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow_cnt != $past(overflow_cnt)) |-> $past(ready));

endmodule

bind hit_readout_channel hit_readout_channel_chk #(.OVF_W(OVF_W)) u_chk (.*);

// File: tb/test_hit_readout_channel.sv
module test_hit_readout_channel;
  localparam int OVF_W = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_pulse = 1'b0;
  logic [31:0] fine_taps = '0;
  logic [4:0]  grp_addr = '0;
  logic        ser_out, frame_valid, ready;
  logic [OVF_W-1:0] overflow_cnt;

  int n_tests = 0, n_fail = 0, cyc = 0;
  logic [15:0] exp_q[$];

  always #2.5 clk = ~clk;

  hit_readout_channel #(.OVF_W(OVF_W)) i_hit_readout_channel (
    .clk(clk), .rst_n(rst_n), .rx_pulse(rx_pulse), .fine_taps(fine_taps),
    .grp_addr(grp_addr), .ser_out(ser_out), .frame_valid(frame_valid),
    .ready(ready), .overflow_cnt(overflow_cnt));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: frame timing and contents
  logic prev_rdy = 1'b0, prev_fv = 1'b0;
  int rose_at = -10, nbits = 0;
  logic [15:0] got;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (ready && !prev_rdy) rose_at = cyc;
      if (frame_valid && !prev_fv) begin
        chk("R6 start", cyc - rose_at, 1);
        nbits = 0;
      end
      if (frame_valid) begin
        got = {got[14:0], ser_out};
        nbits++;
      end else if (ser_out) chk("R6 idle line", 32'(ser_out), 0);
      if (!frame_valid && prev_fv) begin
        chk("R6 length", nbits, 16);
        chk("R7 ready drop", 32'(ready), 0);
        if (exp_q.size() == 0) chk("R6 unexpected frame", 32'(got), 32'hFFFF_FFFF);
        else chk("R6 frame", 32'(got), 32'(exp_q.pop_front()));
      end
    end
    prev_rdy = ready;
    prev_fv  = frame_valid;
  end

  task automatic send_hit(logic [4:0] addr, logic [31:0] lt, logic [31:0] tt,
                          logic [4:0] el, logic [4:0] et, logic ee, int extra);
    exp_q.push_back({addr, el, et, ee});
    fine_taps = lt; grp_addr = addr; rx_pulse = 1'b1;           // R2
    @(negedge clk);
    fine_taps = ~lt; grp_addr = ~addr;
    repeat (3) @(negedge clk);
    fine_taps = tt; rx_pulse = 1'b0;                            // R3
    @(negedge clk);
    fine_taps = ~tt;
    chk("R3 ready", 32'(ready), 1);
    for (int k = 0; k < extra; k++) begin                       // R8
      rx_pulse = 1'b1; @(negedge clk);
      rx_pulse = 1'b0; @(negedge clk);
    end
    while (ready) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(negedge clk);
        chk("watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    chk("R1 ser_out", 32'(ser_out), 0);
    chk("R1 frame_valid", 32'(frame_valid), 0);
    chk("R1 ready", 32'(ready), 0);
    chk("R1 overflow", 32'(overflow_cnt), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R4 thermometer codes
    send_hit(5'h03, 32'h0000_00FF, 32'h000F_FFFF, 5'd7, 5'd19, 1'b0, 0);
    // R5 all ones lead
    send_hit(5'h0A, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0, 5'd0, 1'b1, 0);
    // R5 all zeros trail, R4 index 30
    send_hit(5'h11, 32'h7FFF_FFFF, 32'h0000_0000, 5'd30, 5'd0, 1'b1, 0);
    // R4 bubble picks lowest, R5 only top bit set
    send_hit(5'h15, 32'hF0F0_00F3, 32'h8000_0000, 5'd1, 5'd0, 1'b1, 0);
    // R8 dropped edges during readout
    send_hit(5'h1F, 32'h0000_0003, 32'h0000_01FF, 5'd1, 5'd8, 1'b0, 3);
    chk("R8 overflow count", 32'(overflow_cnt), 3);
    // R7 immediate re-arm, R9 saturation
    send_hit(5'h06, 32'h0000_FFFF, 32'h00FF_FFFF, 5'd15, 5'd23, 1'b0, 6);
    chk("R9 overflow saturates", 32'(overflow_cnt), 7);
    send_hit(5'h09, 32'h0000_000F, 32'h3FFF_FFFF, 5'd3, 5'd29, 1'b0, 0);
    chk("R9 overflow held", 32'(overflow_cnt), 7);
    repeat (5) @(negedge clk);
    chk("R6 all frames seen", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule